// File: doc/BRIEF.md
# Bit-Set Accumulating Dual-Port Memory

This block stores a table of small words and builds each word up one bit at a time. Every clock cycle the write side may deliver one event: a word address and a bit index. The block sets that one bit in the addressed word and keeps every bit that was already set, so repeated events to the same word accumulate as a running OR. An independent read port returns any word one cycle after its address is presented, in parallel with the event stream.

The storage is a synchronous RAM whose read data appears one clock after the address. Each update is therefore a two-stage read-modify-write. A forwarding path hands the most recently written word to the next update, so events run back to back at full rate, including long runs aimed at the same word. A clear sequencer can zero the whole table. It walks every address in turn and raises a busy flag while it runs.

Top module: `bitset_accum_mem`

## Requirements
- R1: The memory holds DEPTH words of WIDTH bits (defaults 512 and 6). `rd_data` shows the word at the `rd_addr` sampled on the previous rising edge.
- R2: An accepted event with `set_idx` in 0..WIDTH-1 sets bit `set_idx` (bit 0 is the least significant) of the word at `set_addr`. All other bits of that word keep their value.
- R3: Events are accepted on every cycle without stalls. Back-to-back events to one address, and events that alternate between addresses, all reach the stored words with no set bit lost.
- R4: A read issued in the cycle after an event returns the word as it was before that event. A read issued two or more cycles after the event returns the updated word.
- R5: An event whose `set_idx` is WIDTH or larger leaves memory unchanged. `bad_idx` is high in that same cycle, and only then.
- R6: A pulse on `clear_start` while idle makes `clear_busy` high from the next cycle for exactly DEPTH cycles. After that every word reads as zero.
- R7: Events presented while `clear_busy` is high, or in the cycle `clear_start` is high, are dropped. They do not raise `bad_idx` and change no word.
- R8: While reset is held and right after it, `clear_busy` and `bad_idx` are low.
- R9: `clear_start` while `clear_busy` is high is ignored and does not lengthen the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset of control state |
| set_valid | input | 1 | Event present this cycle |
| set_addr | input | 9 | Word address of the event |
| set_idx | input | 3 | Bit index to set |
| rd_addr | input | 9 | Read address |
| rd_data | output | 6 | Word read, one cycle after `rd_addr` |
| bad_idx | output | 1 | Event this cycle carries an out-of-range index |
| clear_start | input | 1 | Start zeroing the whole memory |
| clear_busy | output | 1 | Clear sequence in progress |

## Verification
The accumulate path is tested with four patterns:
- Isolated events to scattered words, which separate a correct bit placement from a plain overwrite.
- A run of six consecutive events to one word. This shows whether the forwarding path keeps every bit or loses the ones still in flight.
- Alternating and paired address streams. These check that forwarding triggers only on a true address match.
- A read placed one cycle and then two cycles after an event, which fixes the read-before-write ordering.

Out-of-range indices, events during a clear, and a restart request during a clear are each followed by read-back of the words they could have touched.

// File: rtl/bam_pkg.sv
package bam_pkg;

   // One-hot mask for a bit index; all zero when the index is out of range.
   function automatic logic [63:0] bam_onehot(input int unsigned idx, input int unsigned width);
      logic [63:0] m;
      m = '0;
      for (int unsigned i = 0; i < 64; i++) begin
         if (i < width && i == idx) m[i] = 1'b1;
      end
      return m;
   endfunction

endpackage

// File: rtl/bam_ram.sv
module bam_ram #(
   parameter int DEPTH  = 512,
   parameter int WIDTH  = 6,
   localparam int AW    = $clog2(DEPTH)
) (
   input  logic             clk,
   input  logic             we,
   input  logic [AW-1:0]    waddr,
   input  logic [WIDTH-1:0] wdata,
   input  logic [AW-1:0]    ra_addr,
   output logic [WIDTH-1:0] ra_q,
   input  logic [AW-1:0]    rb_addr,
   output logic [WIDTH-1:0] rb_q
);

   logic [WIDTH-1:0] mem [DEPTH];

   // Both read ports see the contents before a same-edge write.
   always_ff @(posedge clk) begin
      if (we) mem[waddr] <= wdata;
      ra_q <= mem[ra_addr];
      rb_q <= mem[rb_addr];
   end

endmodule

// File: rtl/bam_clear_seq.sv
module bam_clear_seq #(
   parameter int DEPTH = 512,
   localparam int AW   = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   output logic          busy,
   output logic [AW-1:0] addr
);

   localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy <= 1'b0;
         addr <= '0;
      end else if (busy) begin
         if (addr == LAST) busy <= 1'b0;
         addr <= addr + 1'b1;
      end else if (start) begin
         busy <= 1'b1;
         addr <= '0;
      end
   end

endmodule

// File: rtl/bam_rmw_pipe.sv
module bam_rmw_pipe #(
   parameter int DEPTH = 512,
   parameter int WIDTH = 6,
   localparam int AW   = $clog2(DEPTH)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             kill,
   input  logic             ev_valid,
   input  logic [AW-1:0]    ev_addr,
   input  logic [WIDTH-1:0] ev_mask,
   input  logic [WIDTH-1:0] ram_q,
   output logic             wr_en,
   output logic [AW-1:0]    wr_addr,
   output logic [WIDTH-1:0] wr_data
);

   logic             s1_v;
   logic [AW-1:0]    s1_addr;
   logic [WIDTH-1:0] s1_mask;
   logic             wb_v;
   logic [AW-1:0]    wb_addr;
   logic [WIDTH-1:0] wb_data;
   logic             fwd_hit;
   logic [WIDTH-1:0] base;

   // Stage 1 waits for the storage read issued in the accept cycle.
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         s1_v <= 1'b0;
      end else begin
         s1_v <= ev_valid;
      end
      s1_addr <= ev_addr;
      s1_mask <= ev_mask;
   end

   // The last written word: storage read in the same edge missed it.
   always_ff @(posedge clk) begin
      if (!rst_n || kill) begin
         wb_v <= 1'b0;
      end else begin
         wb_v <= s1_v;
      end
      wb_addr <= s1_addr;
      wb_data <= wr_data;
   end

   assign fwd_hit = wb_v && (wb_addr == s1_addr);
   assign base    = fwd_hit ? wb_data : ram_q;
   assign wr_en   = s1_v;
   assign wr_addr = s1_addr;
   assign wr_data = base | s1_mask;

endmodule

// File: rtl/bitset_accum_mem.sv
module bitset_accum_mem #(
   parameter int DEPTH = 512,
   parameter int WIDTH = 6,
   localparam int AW   = $clog2(DEPTH),
   localparam int IW   = (WIDTH > 1) ? $clog2(WIDTH) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             set_valid,
   input  logic [AW-1:0]    set_addr,
   input  logic [IW-1:0]    set_idx,
   input  logic [AW-1:0]    rd_addr,
   output logic [WIDTH-1:0] rd_data,
   output logic             bad_idx,
   input  logic             clear_start,
   output logic             clear_busy
);

   import bam_pkg::*;

   generate
      if (DEPTH < 2) begin : g_depth_bad
         $error("bitset_accum_mem: DEPTH must be at least 2");
      end
      if (WIDTH < 2 || WIDTH > 64) begin : g_width_bad
         $error("bitset_accum_mem: WIDTH must be in 2..64");
      end
   endgenerate

   logic             gate_off;
   logic             idx_ok;
   logic             ev_ok;
   logic [WIDTH-1:0] ev_mask;
   logic [AW-1:0]    clr_addr;
   logic             p_we;
   logic [AW-1:0]    p_waddr;
   logic [WIDTH-1:0] p_wdata;
   logic [WIDTH-1:0] ram_qa;
   logic             ram_we;
   logic [AW-1:0]    ram_waddr;
   logic [WIDTH-1:0] ram_wdata;
   logic [63:0]      mask_full;

   assign gate_off  = clear_busy || clear_start;
   assign idx_ok    = int'(set_idx) < WIDTH;
   assign ev_ok     = set_valid && !gate_off && idx_ok;
   assign bad_idx   = set_valid && !gate_off && !idx_ok;
   assign mask_full = bam_onehot(int'(set_idx), WIDTH);

   generate
      for (genvar i = 0; i < WIDTH; i++) begin : g_mask
         assign ev_mask[i] = mask_full[i];
      end
   endgenerate

   bam_clear_seq #(.DEPTH(DEPTH)) u_clr (
      .clk   (clk),
      .rst_n (rst_n),
      .start (clear_start),
      .busy  (clear_busy),
      .addr  (clr_addr)
   );

   bam_rmw_pipe #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_pipe (
      .clk      (clk),
      .rst_n    (rst_n),
      .kill     (clear_busy),
      .ev_valid (ev_ok),
      .ev_addr  (set_addr),
      .ev_mask  (ev_mask),
      .ram_q    (ram_qa),
      .wr_en    (p_we),
      .wr_addr  (p_waddr),
      .wr_data  (p_wdata)
   );

   // Clear owns the write port while busy.
   assign ram_we    = clear_busy || p_we;
   assign ram_waddr = clear_busy ? clr_addr : p_waddr;
   assign ram_wdata = clear_busy ? '0 : p_wdata;

   bam_ram #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_ram (
      .clk     (clk),
      .we      (ram_we),
      .waddr   (ram_waddr),
      .wdata   (ram_wdata),
      .ra_addr (set_addr),
      .ra_q    (ram_qa),
      .rb_addr (rd_addr),
      .rb_q    (rd_data)
   );

endmodule

// File: rtl/bam_chk.sv
module bam_chk #(
   parameter int DEPTH = 512,
   parameter int WIDTH = 6
) (
   input logic             clk,
   input logic             rst_n,
   input logic             set_valid,
   input logic             clear_start,
   input logic             clear_busy,
   input logic             bad_idx,
   input logic             ram_we,
   input logic [WIDTH-1:0] ram_wdata
);

   localparam int CW = $clog2(DEPTH) + 2;
   logic [CW-1:0] busy_cnt;

   always_ff @(posedge clk) begin
      if (!rst_n)          busy_cnt <= '0;
      else if (clear_busy) busy_cnt <= busy_cnt + 1'b1;
      else                 busy_cnt <= '0;
   end

   // R6
   clear_starts_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clear_start && !clear_busy) |=> clear_busy);

   // R6
   clear_length_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(clear_busy) |-> (busy_cnt == CW'(DEPTH)));

   // R7
   no_err_in_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bad_idx |-> (set_valid && !clear_busy && !clear_start));

   // R6
   clear_writes_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clear_busy |-> (ram_we && ram_wdata == '0));

   // R2
   update_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ram_we && !clear_busy) |-> (ram_wdata != '0));

endmodule

bind bitset_accum_mem bam_chk #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .set_valid   (set_valid),
   .clear_start (clear_start),
   .clear_busy  (clear_busy),
   .bad_idx     (bad_idx),
   .ram_we      (ram_we),
   .ram_wdata   (ram_wdata)
);

// File: tb/bitset_accum_mem_bench.sv
module bitset_accum_mem_bench;

   localparam int DEPTH = 512;
   localparam int WIDTH = 6;
   localparam int AW    = 9;
   localparam int IW    = 3;

   logic clk = 1'b0;
   always #10 clk = ~clk;

   logic             rst_n, set_valid, clear_start;
   logic [AW-1:0]    set_addr, rd_addr;
   logic [IW-1:0]    set_idx;
   logic [WIDTH-1:0] rd_data;
   logic             bad_idx, clear_busy;

   int checks   = 0;
   int failures = 0;
   logic [WIDTH-1:0] model [DEPTH];

   bitset_accum_mem u_bitset_accum_mem (
      .clk(clk), .rst_n(rst_n), .set_valid(set_valid), .set_addr(set_addr),
      .set_idx(set_idx), .rd_addr(rd_addr), .rd_data(rd_data), .bad_idx(bad_idx),
      .clear_start(clear_start), .clear_busy(clear_busy)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic send(input int a, input int idx);
      @(negedge clk);
      set_valid = 1'b1;
      set_addr  = AW'(a);
      set_idx   = IW'(idx);
      if (idx < WIDTH) model[a][idx] = 1'b1;
   endtask

   task automatic read_chk(input int a, input string req);
      @(negedge clk);
      set_valid = 1'b0;
      @(negedge clk);
      rd_addr = AW'(a);
      @(negedge clk);
      chk(rd_data == model[a], req, int'(rd_data), int'(model[a]));
   endtask

   task automatic t_reset;
      rst_n = 1'b0; set_valid = 1'b0; clear_start = 1'b0;
      set_addr = '0; set_idx = '0; rd_addr = '0;
      repeat (3) @(negedge clk);
      chk(clear_busy == 1'b0, "R8 busy in reset", int'(clear_busy), 0);
      chk(bad_idx == 1'b0, "R8 bad_idx in reset", int'(bad_idx), 0);
      @(negedge clk) rst_n = 1'b1;
      @(negedge clk);
      chk(clear_busy == 1'b0, "R8 busy after reset", int'(clear_busy), 0);
   endtask

   // Clear with events during it; optionally a restart request mid-way.
   task automatic t_clear(input bit restart, input string req);
      int n;
      bit err_seen;
      n = 0; err_seen = 0;
      @(negedge clk);
      clear_start = 1'b1;
      set_valid = 1'b1; set_addr = AW'(40); set_idx = 3'd2;  // dropped (R7)
      @(negedge clk);
      clear_start = 1'b0;
      while (clear_busy && n < 2000) begin
         n++;
         set_valid   = 1'b1;
         set_addr    = AW'(n % 64);
         set_idx     = (n % 7 == 0) ? 3'd7 : IW'(n % WIDTH);
         clear_start = restart && (n == 100);
         #2;
         if (bad_idx) err_seen = 1;
         @(negedge clk);
      end
      set_valid = 1'b0; clear_start = 1'b0;
      chk(n == DEPTH, req, n, DEPTH);
      chk(!err_seen, "R7 no bad_idx during clear", int'(err_seen), 0);
      for (int i = 0; i < DEPTH; i++) model[i] = '0;
      read_chk(0, "R6 word 0 cleared");
      read_chk(DEPTH - 1, "R6 last word cleared");
      read_chk(40, "R7 event in start cycle dropped");
      read_chk(5, "R7 event during clear dropped");
   endtask

   task automatic t_single;
      send(3, 0);
      send(100, 5);
      send(257, 2);
      send(3, 4);
      read_chk(3, "R2 bits 0 and 4 kept");
      read_chk(100, "R2 bit 5");
      read_chk(257, "R1 word 257 bit 2");
      read_chk(101, "R2 neighbour untouched");
   endtask

   task automatic t_burst_same;
      for (int b = 0; b < WIDTH; b++) send(77, b);
      read_chk(77, "R3 six back-to-back to one word");
   endtask

   task automatic t_interleave;
      send(10, 0); send(11, 1); send(10, 2); send(11, 3);
      send(10, 4); send(10, 5); send(11, 0);
      read_chk(10, "R3 alternating addr A");
      read_chk(11, "R3 alternating addr B");
   endtask

   task automatic t_bad;
      send(20, 1);
      read_chk(20, "R2 preset word 20");
      @(negedge clk);
      set_valid = 1'b1; set_addr = AW'(20); set_idx = 3'd6;
      #2 chk(bad_idx == 1'b1, "R5 idx 6 flags", int'(bad_idx), 1);
      @(negedge clk);
      set_idx = 3'd7;
      #2 chk(bad_idx == 1'b1, "R5 idx 7 flags", int'(bad_idx), 1);
      @(negedge clk);
      set_idx = 3'd3; set_valid = 1'b0;
      #2 chk(bad_idx == 1'b0, "R5 no flag when idle", int'(bad_idx), 0);
      read_chk(20, "R5 word unchanged by bad index");
   endtask

   task automatic t_rbw;
      logic [WIDTH-1:0] old_w;
      send(300, 1);
      read_chk(300, "R4 preset");
      old_w = model[300];
      send(300, 3);
      @(negedge clk);
      set_valid = 1'b0;
      rd_addr = AW'(300);
      @(negedge clk);
      chk(rd_data == old_w, "R4 read next cycle gives old", int'(rd_data), int'(old_w));
      @(negedge clk);
      chk(rd_data == model[300], "R4 read two cycles later gives new",
          int'(rd_data), int'(model[300]));
   endtask

   initial begin
      t_reset();
      t_clear(1'b0, "R6 busy lasts DEPTH cycles");
      t_single();
      t_burst_same();
      t_interleave();
      t_bad();
      t_rbw();
      t_clear(1'b1, "R9 restart ignored, length DEPTH");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      #(20 * 200000);
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule